// File: doc/BRIEF.md
# I2C Command-Queue Master Sequencer

This block is the sequencing half of an I2C master. Software does not hand it one byte at a time. It loads a short list of encoded command words into slot registers and puts outgoing bytes into a transmit FIFO. A single start pulse then runs the whole list. The sequencer walks the slots from slot 0 and performs each command in turn: a start or repeated start, a burst of written bytes with an optional check of the acknowledge bit, a burst of read bytes with a chosen acknowledge level, a stop, or an end marker. An end marker pauses the list with the bus still held.

The sequencer does not generate SCL or SDA waveforms. For each bus event it issues a one-cycle request to a separate timing engine: start, stop, one data bit, or release of both lines. It then waits for that engine's completion pulse, which also returns the SDA level sampled during the bit. Bytes that are read land in a receive FIFO. The sequencer reports completion, acknowledge errors, lost arbitration and stalls through four latched interrupt flags. A busy output shows that the bus is owned.

Top module: `i2c_cmdq_master`

## Requirements
- R1: A command word holds a byte count in bits 7:0, an acknowledge-check enable in bit 8, the expected acknowledge level in bit 9, the acknowledge level sent after a received byte in bit 10, an opcode in bits 13:11 (0 start, 1 write, 2 read, 3 stop, 4 end) and a done flag in bit 31. A start pulse begins execution at slot 0. A start pulse that arrives while a list is running has no effect.
- R2: A write command pops its byte count of bytes from the transmit FIFO. For each byte it sends eight data bits, MSB first when tx_lsb is 0 and LSB first when tx_lsb is 1, followed by one released bit (level 1) in which the acknowledge is sampled.
- R3: A read command sends eight released bits for each byte and then one bit at the slot's acknowledge level. It pushes its byte count of assembled bytes into the receive FIFO, with the first sampled bit taken as the MSB when rx_lsb is 0 and as the LSB when rx_lsb is 1.
- R4: The done flag (bit 31) of a slot reads 1 after that command has completed. A software write to a slot replaces the whole word, including the done flag.
- R5: When the acknowledge check is enabled and the sampled acknowledge differs from the expected level, flag bit 0 (acknowledge error) is set. The list then stops without a stop condition, a release request is issued, and the failing slot is not marked done.
- R6: When a write data bit is sent as 1 and sampled as 0, flag bit 3 (arbitration lost) is set, a release request is issued and the list stops.
- R7: With timeout_lim non-zero, if a request goes unanswered for timeout_lim cycles, flag bit 1 (timeout) is set, a release request is issued and the list stops. A timeout_lim of 0 disables this check.
- R8: An end command sets flag bit 2 (complete) and leaves busy high with no stop sent. The next start pulse resumes execution at slot 0.
- R9: A stop command sets flag bit 2 (complete) after the timing engine completes it, and then the sequencer goes idle.
- R10: busy rises when a start condition completes. It falls only when a stop condition completes or a release request is issued.
- R11: Each flag stays set until a 1 is written to the matching int_clr bit. irq is high whenever a set flag has its int_en bit set.
- R12: Holding tx_rst or rx_rst high empties the matching FIFO. Bytes pushed before the reset are never sent or read.
- R13: Requests to the timing engine are one-cycle bit_go pulses with bit_op encoded as 0 start, 1 stop, 2 data bit, 3 release. No new non-release request is issued while one is still outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that runs the command list from slot 0 |
| cmd_we | input | 1 | Slot write strobe |
| cmd_addr | input | 4 | Slot write index |
| cmd_wdata | input | 32 | Slot write data |
| cmd_raddr | input | 4 | Slot read index |
| cmd_rdata | output | 32 | Slot contents, including the done flag |
| tx_push | input | 1 | Push tx_data into the transmit FIFO |
| tx_data | input | 8 | Byte to transmit |
| tx_full | output | 1 | Transmit FIFO is full |
| rx_pop | input | 1 | Pop the head of the receive FIFO |
| rx_data | output | 8 | Head of the receive FIFO |
| rx_empty | output | 1 | Receive FIFO is empty |
| tx_rst | input | 1 | Transmit FIFO flush while high |
| rx_rst | input | 1 | Receive FIFO flush while high |
| tx_lsb | input | 1 | Transmit LSB first |
| rx_lsb | input | 1 | Receive LSB first |
| timeout_lim | input | 16 | Stall limit in cycles, 0 disables |
| int_en | input | 4 | Flag enables |
| int_clr | input | 4 | Write-one-to-clear flag strobes |
| int_raw | output | 4 | Latched flags: 0 ack error, 1 timeout, 2 complete, 3 arbitration lost |
| irq | output | 1 | Interrupt request |
| busy | output | 1 | Bus owned |
| bit_go | output | 1 | Request pulse to the timing engine |
| bit_op | output | 2 | Request type |
| bit_wdata | output | 1 | SDA level to drive for a data bit |
| bit_done | input | 1 | Timing engine completion pulse |
| bit_rdata | input | 1 | SDA level sampled during the bit |

## Verification
The bench pairs the design with a wire-AND bus model. The bus model returns, for every bit, the level the master drove ANDed with a scripted slave level. The bench predicts the exact request stream from the command list. A multi-byte MSB-first write against an LSB-first read with mixed acknowledge levels shows whether bit order is handled separately for each direction and whether the acknowledge bit is sent correctly. A list interrupted by a stray start pulse shows whether that pulse is ignored. A nack, a low sample on a driven-high bit and a stalled engine each show whether the right flag is raised, whether a release replaces the stop and whether busy drops. An end-paused list followed by a one-slot stop list shows that resumption begins at slot 0. A flush-then-push pattern shows that stale bytes never reach the bus.

// File: rtl/i2c_cmdq_master.sv
module i2c_cmdq_master #(
  parameter int SLOTS      = 16,
  parameter int FIFO_DEPTH = 32,
  parameter int TO_W       = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     cmd_we,
  input  logic [$clog2(SLOTS)-1:0] cmd_addr,
  input  logic [31:0]              cmd_wdata,
  input  logic [$clog2(SLOTS)-1:0] cmd_raddr,
  output logic [31:0]              cmd_rdata,
  input  logic                     tx_push,
  input  logic [7:0]               tx_data,
  output logic                     tx_full,
  input  logic                     rx_pop,
  output logic [7:0]               rx_data,
  output logic                     rx_empty,
  input  logic                     tx_rst,
  input  logic                     rx_rst,
  input  logic                     tx_lsb,
  input  logic                     rx_lsb,
  input  logic [TO_W-1:0]          timeout_lim,
  input  logic [3:0]               int_en,
  input  logic [3:0]               int_clr,
  output logic [3:0]               int_raw,
  output logic                     irq,
  output logic                     busy,
  output logic                     bit_go,
  output logic [1:0]               bit_op,
  output logic                     bit_wdata,
  input  logic                     bit_done,
  input  logic                     bit_rdata
);
  localparam int SW = $clog2(SLOTS);
  localparam int FW = $clog2(FIFO_DEPTH);
  localparam logic [1:0] B_START = 2'd0, B_STOP = 2'd1, B_BIT = 2'd2, B_REL = 2'd3;

  typedef enum logic [1:0] {IDLE, DEC, ISSUE, WAIT} st_t;
  st_t st;

  logic [31:0] slot [SLOTS];
  logic [7:0]  tx_mem [FIFO_DEPTH];
  logic [7:0]  rx_mem [FIFO_DEPTH];
  logic [FW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [FW:0]   tx_cnt, rx_cnt;
  logic [SW:0]   pc;
  logic [7:0]    left, sh, rx_byte;
  logic [3:0]    bitn, set_q;
  logic [TO_W-1:0] tmr;
  logic          tx_pop_q, rx_push_q, mk;
  logic [SW-1:0] mk_idx;

  wire [13:0] cur       = slot[pc[SW-1:0]][13:0];
  wire [2:0]  opc       = cur[13:11];
  wire        is_wr     = opc == 3'd1;
  wire        lsb       = is_wr ? tx_lsb : rx_lsb;
  wire        ack_phase = bitn == 4'd8;

  assign cmd_rdata = slot[cmd_raddr];
  assign tx_full   = tx_cnt == (FW+1)'(FIFO_DEPTH);
  assign rx_empty  = rx_cnt == '0;
  assign rx_data   = rx_mem[rx_rp];
  assign irq       = |(int_raw & int_en);

  wire tx_wr_ok = tx_push && !tx_full;
  wire tx_rd_ok = tx_pop_q && tx_cnt != '0;
  wire rx_wr_ok = rx_push_q && rx_cnt != (FW+1)'(FIFO_DEPTH);
  wire rx_rd_ok = rx_pop && !rx_empty;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n || tx_rst) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_wr_ok) tx_wp <= tx_wp + 1'b1;
      if (tx_rd_ok) tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + (FW+1)'(tx_wr_ok) - (FW+1)'(tx_rd_ok);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n || rx_rst) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_wr_ok) rx_wp <= rx_wp + 1'b1;
      if (rx_rd_ok) rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + (FW+1)'(rx_wr_ok) - (FW+1)'(rx_rd_ok);
    end

  always_ff @(posedge clk) begin
    if (tx_wr_ok) tx_mem[tx_wp] <= tx_data;
    if (rx_wr_ok) rx_mem[rx_wp] <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) slot[i] <= '0;
    end else begin
      if (cmd_we) slot[cmd_addr] <= cmd_wdata;
      if (mk) slot[mk_idx][31] <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) int_raw <= '0;
    else        int_raw <= (int_raw & ~int_clr) | set_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= IDLE; pc <= '0; left <= '0; sh <= '0; bitn <= '0; tmr <= '0;
      busy <= 1'b0; bit_go <= 1'b0; bit_op <= B_START; bit_wdata <= 1'b1;
      set_q <= '0; tx_pop_q <= 1'b0; rx_push_q <= 1'b0; rx_byte <= '0;
      mk <= 1'b0; mk_idx <= '0;
    end else begin
      bit_go <= 1'b0; set_q <= '0; tx_pop_q <= 1'b0; rx_push_q <= 1'b0; mk <= 1'b0;
      case (st)
        IDLE: if (start) begin pc <= '0; st <= DEC; end
        DEC: begin
          tmr <= '0;
          if (pc == (SW+1)'(SLOTS)) begin
            set_q[2] <= 1'b1; st <= IDLE;
          end else case (opc)
            3'd0: begin bit_go <= 1'b1; bit_op <= B_START; st <= WAIT; end
            3'd1, 3'd2:
              if (cur[7:0] == 8'd0) begin
                mk <= 1'b1; mk_idx <= pc[SW-1:0]; pc <= pc + 1'b1;
              end else begin
                left <= cur[7:0]; bitn <= '0; st <= ISSUE;
                if (is_wr) begin sh <= tx_mem[tx_rp]; tx_pop_q <= 1'b1; end
              end
            3'd3: begin bit_go <= 1'b1; bit_op <= B_STOP; st <= WAIT; end
            default: begin
              mk <= 1'b1; mk_idx <= pc[SW-1:0]; set_q[2] <= 1'b1; st <= IDLE;
            end
          endcase
        end
        ISSUE: begin
          bit_go <= 1'b1; bit_op <= B_BIT; tmr <= '0; st <= WAIT;
          if (ack_phase) bit_wdata <= is_wr ? 1'b1 : cur[10];
          else           bit_wdata <= is_wr ? (lsb ? sh[0] : sh[7]) : 1'b1;
        end
        WAIT:
          if (bit_done) begin
            tmr <= '0;
            case (bit_op)
              B_START: begin
                busy <= 1'b1; mk <= 1'b1; mk_idx <= pc[SW-1:0]; pc <= pc + 1'b1; st <= DEC;
              end
              B_STOP: begin
                busy <= 1'b0; mk <= 1'b1; mk_idx <= pc[SW-1:0]; set_q[2] <= 1'b1; st <= IDLE;
              end
              default:
                if (!ack_phase) begin
                  if (is_wr && bit_wdata && !bit_rdata) begin
                    set_q[3] <= 1'b1; bit_go <= 1'b1; bit_op <= B_REL; busy <= 1'b0; st <= IDLE;
                  end else begin
                    sh <= lsb ? {bit_rdata, sh[7:1]} : {sh[6:0], bit_rdata};
                    bitn <= bitn + 1'b1; st <= ISSUE;
                  end
                end else if (cur[8] && bit_rdata != cur[9]) begin
                  set_q[0] <= 1'b1; bit_go <= 1'b1; bit_op <= B_REL; busy <= 1'b0; st <= IDLE;
                end else begin
                  if (!is_wr) begin rx_push_q <= 1'b1; rx_byte <= sh; end
                  left <= left - 1'b1; bitn <= '0;
                  if (left == 8'd1) begin
                    mk <= 1'b1; mk_idx <= pc[SW-1:0]; pc <= pc + 1'b1; st <= DEC;
                  end else begin
                    if (is_wr) begin sh <= tx_mem[tx_rp]; tx_pop_q <= 1'b1; end
                    st <= ISSUE;
                  end
                end
            endcase
          end else if (timeout_lim != '0 && tmr == timeout_lim - 1'b1) begin
            set_q[1] <= 1'b1; bit_go <= 1'b1; bit_op <= B_REL; busy <= 1'b0; st <= IDLE;
          end else tmr <= tmr + 1'b1;
        default: st <= IDLE;
      endcase
    end
endmodule

// File: rtl/i2c_cmdq_master_chk.sv
module i2c_cmdq_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       bit_go,
  input logic [1:0] bit_op,
  input logic       bit_done,
  input logic [3:0] int_raw,
  input logic [3:0] int_clr,
  input logic       rx_rst,
  input logic       rx_empty
);
  logic pend;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pend <= 1'b0;
    else if (bit_go) pend <= bit_op != 2'd3;
    else if (bit_done) pend <= 1'b0;

  AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(bit_done) && $past(bit_op) == 2'd0)); // R10
  AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (($past(bit_done) && $past(bit_op) == 2'd1) || (bit_go && bit_op == 2'd3))); // R10
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_go && bit_op != 2'd3) |-> !pend); // R13
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(int_raw) & ~int_raw & ~$past(int_clr)) == 4'd0)); // R11
  AST_RX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rst |=> rx_empty); // R12
endmodule

bind i2c_cmdq_master i2c_cmdq_master_chk u_chk (.*);

// File: tb/sim_i2c_cmdq_master.sv
module sim_i2c_cmdq_master;
  logic clk = 0, rst_n = 0, start = 0, cmd_we = 0;
  logic [3:0] cmd_addr = 0, cmd_raddr = 0;
  logic [31:0] cmd_wdata = 0, cmd_rdata;
  logic tx_push = 0, tx_full, rx_pop = 0, rx_empty, tx_rst = 0, rx_rst = 0;
  logic tx_lsb = 0, rx_lsb = 0, irq, busy, bit_go, bit_wdata;
  logic [7:0] tx_data = 0, rx_data;
  logic [15:0] timeout_lim = 16'd200;
  logic [3:0] int_en = 0, int_clr = 0, int_raw;
  logic [1:0] bit_op;
  logic bit_done = 0, bit_rdata = 1, rd_h = 1, stall = 0;
  int lat = 0, checks = 0, fails = 0, cyc = 0;
  int log_q[$], exp_q[$];
  bit sq[$];

  always #5 clk = ~clk;

  i2c_cmdq_master u0 (.*);

  // wire-AND bus model standing in for the timing engine
  always @(posedge clk) begin
    bit_done <= 1'b0;
    if (bit_go) begin
      log_q.push_back(bit_op == 2'd2 ? 4 + int'(bit_wdata) : int'(bit_op) * 2);
      rd_h = 1'b1;
      if (bit_op == 2'd2) rd_h = bit_wdata & (sq.size() > 0 ? sq.pop_front() : 1'b1);
      if (bit_op != 2'd3 && !stall) lat <= 3; else lat <= 0;
    end else if (lat > 1) lat <= lat - 1;
    else if (lat == 1) begin lat <= 0; bit_done <= 1'b1; bit_rdata <= rd_h; end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      checks++;
      if (irq !== |(int_raw & int_en)) begin
        fails++; $display("FAIL R11 irq act=%b exp=%b", irq, |(int_raw & int_en));
      end
    end
    if (cyc > 100000) begin
      fails++; $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act !== exp) begin fails++; $display("FAIL %s act=%0h exp=%0h", r, act, exp); end
  endtask

  function automatic logic [31:0] cw(int op, int cnt, bit aen = 0, bit aexp = 0, bit aval = 0);
    return {18'd0, 3'(op), aval, aexp, aen, 8'(cnt)};
  endfunction

  task automatic wslot(int i, logic [31:0] v);
    @(negedge clk); cmd_we = 1; cmd_addr = 4'(i); cmd_wdata = v;
    @(negedge clk); cmd_we = 0;
  endtask
  task automatic ptx(logic [7:0] b);
    @(negedge clk); tx_push = 1; tx_data = b; @(negedge clk); tx_push = 0;
  endtask
  task automatic go();
    @(negedge clk); start = 1; @(negedge clk); start = 0;
  endtask
  task automatic clr();
    @(negedge clk); int_clr = 4'hF; @(negedge clk); int_clr = 0;
  endtask
  task automatic run();
    go();
    while (int_raw == 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask
  task automatic ewr(logic [7:0] b, bit lsb);
    for (int i = 0; i < 8; i++) exp_q.push_back(4 + int'(lsb ? b[i] : b[7-i]));
    exp_q.push_back(5);
  endtask
  task automatic erd(bit aval);
    for (int i = 0; i < 8; i++) exp_q.push_back(5);
    exp_q.push_back(4 + int'(aval));
  endtask
  task automatic swr(bit ack);
    for (int i = 0; i < 8; i++) sq.push_back(1'b1);
    sq.push_back(ack);
  endtask
  task automatic srd(logic [7:0] b, bit lsb);
    for (int i = 0; i < 8; i++) sq.push_back(lsb ? b[i] : b[7-i]);
    sq.push_back(1'b1);
  endtask
  task automatic chk_log(string r);
    int bad = (log_q.size() != exp_q.size());
    for (int i = 0; i < exp_q.size() && !bad; i++) if (log_q[i] != exp_q[i]) bad = 1;
    checks++;
    if (bad) begin
      fails++; $display("FAIL %s request stream act_len=%0d exp_len=%0d", r, log_q.size(), exp_q.size());
    end
    log_q.delete(); exp_q.delete(); sq.delete();
  endtask
  task automatic done_bit(string r, int i, int exp);
    @(negedge clk); cmd_raddr = 4'(i); #1; chk(r, int'(cmd_rdata[31]), exp);
  endtask

  initial begin
    repeat (3) @(negedge clk); rst_n = 1; @(negedge clk);
    // R1 R10 R11 reset state
    chk("R10 reset busy", busy, 0); chk("R11 reset flags", int_raw, 0);
    chk("R12 reset rx_empty", rx_empty, 1); chk("R13 reset bit_go", bit_go, 0);

    // R2 multi-byte MSB-first write, stray start ignored (R1)
    wslot(0, cw(0, 0)); wslot(1, cw(1, 2, 1, 0)); wslot(2, cw(3, 0));
    ptx(8'hA5); ptx(8'h3C); swr(0); swr(0);
    exp_q.push_back(0); ewr(8'hA5, 0); ewr(8'h3C, 0); exp_q.push_back(2);
    go(); repeat (10) @(negedge clk);
    chk("R10 busy after start", busy, 1);
    start = 1; @(negedge clk); start = 0;
    while (int_raw == 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk_log("R2 R1 write list");
    chk("R9 complete flag", int_raw, 4'b0100); chk("R10 busy after stop", busy, 0);
    done_bit("R4 slot0 done", 0, 1); done_bit("R4 slot1 done", 1, 1); done_bit("R4 slot2 done", 2, 1);
    clr();

    // R3 LSB-first reads with mixed ack levels
    rx_lsb = 1;
    wslot(0, cw(0, 0)); wslot(1, cw(2, 2, 0, 0, 0)); wslot(2, cw(2, 1, 0, 0, 1)); wslot(3, cw(3, 0));
    srd(8'h96, 1); srd(8'h01, 1); srd(8'hC3, 1);
    exp_q.push_back(0); erd(0); erd(0); erd(1); exp_q.push_back(2);
    run(); chk_log("R3 read list");
    chk("R3 rx byte0", rx_data, 8'h96); @(negedge clk); rx_pop = 1; @(negedge clk); rx_pop = 0;
    chk("R3 rx byte1", rx_data, 8'h01); rx_pop = 1; @(negedge clk); rx_pop = 0;
    chk("R3 rx byte2", rx_data, 8'hC3); chk("R12 rx not empty", rx_empty, 0);
    rx_rst = 1; @(negedge clk); rx_rst = 0; @(negedge clk);
    chk("R12 rx flushed", rx_empty, 1);
    clr(); rx_lsb = 0;

    // R5 nack on checked write
    wslot(0, cw(0, 0)); wslot(1, cw(1, 1, 1, 0)); wslot(2, cw(3, 0));
    ptx(8'h55); swr(1);
    exp_q.push_back(0); ewr(8'h55, 0); exp_q.push_back(6);
    run(); chk_log("R5 nack stream");
    chk("R5 ack error flag", int_raw, 4'b0001); chk("R10 busy after abort", busy, 0);
    done_bit("R5 failing slot not done", 1, 0);
    clr();

    // R6 arbitration lost on second bit
    wslot(0, cw(0, 0)); wslot(1, cw(1, 1, 1, 0)); wslot(2, cw(3, 0));
    ptx(8'hF0); sq.push_back(1); sq.push_back(0);
    exp_q.push_back(0); exp_q.push_back(5); exp_q.push_back(5); exp_q.push_back(6);
    run(); chk_log("R6 arb stream");
    chk("R6 arb flag", int_raw, 4'b1000); chk("R6 busy released", busy, 0);
    clr();

    // R7 stalled engine
    timeout_lim = 16'd20; stall = 1;
    wslot(0, cw(0, 0)); wslot(1, cw(3, 0));
    exp_q.push_back(0); exp_q.push_back(6);
    run(); chk_log("R7 timeout stream");
    chk("R7 timeout flag", int_raw, 4'b0010); chk("R7 busy", busy, 0);
    stall = 0; timeout_lim = 16'd200; clr();

    // R8 end pause with LSB-first write, then resume at slot 0
    tx_lsb = 1;
    wslot(0, cw(0, 0)); wslot(1, cw(1, 1, 1, 0)); wslot(2, cw(4, 0));
    ptx(8'h06); swr(0);
    exp_q.push_back(0); ewr(8'h06, 1);
    run(); chk_log("R8 R2 end stream");
    chk("R8 complete flag", int_raw, 4'b0100); chk("R8 busy held", busy, 1);
    done_bit("R4 end slot done", 2, 1);
    // R11 enable and clear
    int_en = 4'b0100; @(negedge clk); chk("R11 irq enabled", irq, 1);
    int_en = 4'b1011; @(negedge clk); chk("R11 irq masked", irq, 0);
    int_en = 4'b0100;
    clr(); chk("R11 flag cleared", int_raw, 0); chk("R11 irq after clear", irq, 0);
    int_en = 0;
    wslot(0, cw(3, 0)); exp_q.push_back(2);
    run(); chk_log("R8 resume at slot0");
    chk("R8 R9 resume complete", int_raw, 4'b0100); chk("R10 busy after resume stop", busy, 0);
    clr(); tx_lsb = 0;

    // R12 stale transmit bytes flushed
    ptx(8'hAA); ptx(8'hBB);
    @(negedge clk); tx_rst = 1; @(negedge clk); tx_rst = 0;
    ptx(8'h11);
    wslot(0, cw(0, 0)); wslot(1, cw(1, 1, 1, 0)); wslot(2, cw(3, 0));
    swr(0); exp_q.push_back(0); ewr(8'h11, 0); exp_q.push_back(2);
    run(); chk_log("R12 tx flush stream");
    chk("R12 complete", int_raw, 4'b0100);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule